// File: doc/BRIEF.md
# Mask-controlled interrupt status group

This block is one interrupt-aggregation group inside a memory-mapped register bank. It holds a status word and a mask word and drives one level-sensitive interrupt line. That line is high while any status bit is set whose mask bit is clear. Hardware event pulses and a software trigger raise status bits. Software clears them by writing ones, the write-1-to-clear convention.

Software cannot write the mask directly. An enable strobe register clears the mask bits selected by the write data, and a disable strobe register sets them. The strobe registers hold no value of their own. A valid-bit parameter sets which of the 32 bit positions exist. The same RTL therefore serves a wide group, a narrow group that starts above bit 0, or a two-bit group. Positions outside the valid set are reserved.

Top module: `intr_grp`

## Requirements
- R1: After reset the status word reads 0, the mask word reads the valid-bit vector (every source masked) and the interrupt output is 0.
- R2: A write to the status offset (0x00) clears each valid status bit whose write-data bit is 1 and leaves bits written with 0 unchanged.
- R3: A write to the mask offset (0x04) has no effect. The mask word reads back unchanged.
- R4: A write to the enable offset (0x08) clears the mask bits where the write data is 1. A read of the enable offset returns 0.
- R5: A write to the disable offset (0x0C) sets the valid mask bits where the write data is 1. A read of the disable offset returns 0.
- R6: A write to the trigger offset (0x10) sets the valid status bits where the write data is 1. A read of the trigger offset returns 0.
- R7: A 1 on a valid bit of the event input during a clock cycle sets that status bit at the end of the cycle.
- R8: If an event pulse and a write-1-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R9: The interrupt output is a register. In each cycle it equals the OR over all bits of (status AND NOT mask) taken one clock earlier.
- R10: Bits outside the valid-bit vector read as 0 in the status and mask words. Writes, triggers and events on those bits have no effect.
- R11: A read at an unmapped offset (0x14 and above, or an address with bits 1:0 not zero) returns 0. A write there changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Access request in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on the address; 0 when no read is requested |
| evt_set | input | 32 | Hardware event pulses, one per status bit |
| irq | output | 1 | Level interrupt output |

## Verification
The bench builds the block with a valid-bit vector of 0x0000_03F0, the narrow group at bits 9:4. This places reserved bits both below and above the live field, so R10 is tested on both sides and the bit mapping cannot pass by accident. ADDR_W stays at 5, so offset 0x14 and the misaligned addresses are reachable as unmapped accesses. A behavioural model compares the interrupt line on every clock across trigger, enable, disable, clear and event traffic. This covers cycles where an event and a clear hit the same bit.

// File: rtl/intr_grp_pkg.sv
package intr_grp_pkg;

  localparam int WORD_W = 32;

  typedef enum logic [2:0] {
    REG_STATUS  = 3'd0,
    REG_MASK    = 3'd1,
    REG_ENABLE  = 3'd2,
    REG_DISABLE = 3'd3,
    REG_TRIGGER = 3'd4,
    REG_NONE    = 3'd7
  } reg_sel_e;

  // Clear first, then set, so a set in the same cycle wins; reserved bits forced to 0.
  function automatic logic [WORD_W-1:0] clear_then_set(
    input logic [WORD_W-1:0] cur,
    input logic [WORD_W-1:0] clr,
    input logic [WORD_W-1:0] set,
    input logic [WORD_W-1:0] valid
  );
    return ((cur & ~clr) | set) & valid;
  endfunction

  function automatic logic any_pending(
    input logic [WORD_W-1:0] status,
    input logic [WORD_W-1:0] mask
  );
    return |(status & ~mask);
  endfunction

endpackage

// File: rtl/intr_grp_decode.sv
module intr_grp_decode
  import intr_grp_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output reg_sel_e          hit,
  output logic              rd_en,
  output logic              wr_status,
  output logic              wr_enable,
  output logic              wr_disable,
  output logic              wr_trigger
);

  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             aligned;
  logic             wr_any;

  assign idx     = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);

  always_comb begin
    hit = REG_NONE;
    if (aligned) begin
      case (idx)
        IDX_W'(0): hit = REG_STATUS;
        IDX_W'(1): hit = REG_MASK;
        IDX_W'(2): hit = REG_ENABLE;
        IDX_W'(3): hit = REG_DISABLE;
        IDX_W'(4): hit = REG_TRIGGER;
        default:   hit = REG_NONE;
      endcase
    end
  end

  assign rd_en      = bus_sel && !bus_wr;
  assign wr_any     = bus_sel && bus_wr;
  assign wr_status  = wr_any && (hit == REG_STATUS);
  assign wr_enable  = wr_any && (hit == REG_ENABLE);
  assign wr_disable = wr_any && (hit == REG_DISABLE);
  assign wr_trigger = wr_any && (hit == REG_TRIGGER);

endmodule

// File: rtl/intr_grp_bits.sv
module intr_grp_bits
  import intr_grp_pkg::*;
#(
  parameter logic [WORD_W-1:0] VALID_MASK = 32'h0FFF_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] st_clr,
  input  logic [WORD_W-1:0] st_set,
  input  logic [WORD_W-1:0] mk_clr,
  input  logic [WORD_W-1:0] mk_set,
  output logic [WORD_W-1:0] status_q,
  output logic [WORD_W-1:0] mask_q
);

  logic [WORD_W-1:0] st_nxt;
  logic [WORD_W-1:0] mk_nxt;

  assign st_nxt = clear_then_set(status_q, st_clr, st_set, VALID_MASK);
  assign mk_nxt = clear_then_set(mask_q, mk_clr, mk_set, VALID_MASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= VALID_MASK;
    end else begin
      status_q <= st_nxt;
      mask_q   <= mk_nxt;
    end
  end

endmodule

// File: rtl/intr_grp_irq.sv
module intr_grp_irq
  import intr_grp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] status_q,
  input  logic [WORD_W-1:0] mask_q,
  output logic              pending_c,
  output logic              irq_q
);

  assign pending_c = any_pending(status_q, mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= pending_c;
  end

endmodule

// File: rtl/intr_grp.sv
module intr_grp
  import intr_grp_pkg::*;
#(
  parameter logic [31:0] VALID_MASK = 32'h0FFF_FFFF,
  parameter int          ADDR_W     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [31:0]       evt_set,
  output logic              irq
);

  reg_sel_e          hit;
  logic              rd_en;
  logic              wr_status;
  logic              wr_enable;
  logic              wr_disable;
  logic              wr_trigger;
  logic [WORD_W-1:0] st_clr;
  logic [WORD_W-1:0] st_set;
  logic [WORD_W-1:0] mk_clr;
  logic [WORD_W-1:0] mk_set;
  logic [WORD_W-1:0] status_q;
  logic [WORD_W-1:0] mask_q;
  logic              pending_c;

  intr_grp_decode #(.ADDR_W(ADDR_W)) u_dec (
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .hit        (hit),
    .rd_en      (rd_en),
    .wr_status  (wr_status),
    .wr_enable  (wr_enable),
    .wr_disable (wr_disable),
    .wr_trigger (wr_trigger)
  );

  // Write-1-to-clear data only on a status write; set sources merge trigger and events.
  assign st_clr = wr_status  ? bus_wdata : '0;
  assign st_set = (wr_trigger ? bus_wdata : '0) | evt_set;
  assign mk_clr = wr_enable  ? bus_wdata : '0;
  assign mk_set = wr_disable ? bus_wdata : '0;

  intr_grp_bits #(.VALID_MASK(VALID_MASK)) u_bits (
    .clk      (clk),
    .rst_n    (rst_n),
    .st_clr   (st_clr),
    .st_set   (st_set),
    .mk_clr   (mk_clr),
    .mk_set   (mk_set),
    .status_q (status_q),
    .mask_q   (mask_q)
  );

  intr_grp_irq u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .status_q  (status_q),
    .mask_q    (mask_q),
    .pending_c (pending_c),
    .irq_q     (irq)
  );

  // Strobe registers store nothing and read as zero, like unmapped offsets.
  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      case (hit)
        REG_STATUS: bus_rdata = status_q;
        REG_MASK:   bus_rdata = mask_q;
        default:    bus_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/intr_grp_chk.sv
module intr_grp_chk #(
  parameter logic [31:0] VALID_MASK = 32'h0FFF_FFFF
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_status,
  input logic        wr_enable,
  input logic        wr_disable,
  input logic        wr_trigger,
  input logic [31:0] bus_wdata,
  input logic [31:0] evt_set,
  input logic [31:0] status_q,
  input logic [31:0] mask_q,
  input logic        irq
);

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (status_q == 32'd0 && mask_q == VALID_MASK && !irq));

  // R2
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_status && ((bus_wdata & ~evt_set & VALID_MASK) != 32'd0))
    |=> ((status_q & $past(bus_wdata & ~evt_set)) == 32'd0));

  // R3
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_enable || wr_disable) |=> $stable(mask_q));

  // R4
  enable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_enable |=> ((mask_q & $past(bus_wdata)) == 32'd0));

  // R5
  disable_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_disable |=> ((mask_q & $past(bus_wdata & VALID_MASK)) == $past(bus_wdata & VALID_MASK)));

  // R6
  trigger_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_trigger |=> ((status_q & $past(bus_wdata & VALID_MASK)) == $past(bus_wdata & VALID_MASK)));

  // R7 R8
  event_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_set & VALID_MASK) != 32'd0)
    |=> ((status_q & $past(evt_set & VALID_MASK)) == $past(evt_set & VALID_MASK)));

  // R9
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(|(status_q & ~mask_q))));

  // R10
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q | mask_q) & ~VALID_MASK) == 32'd0);

endmodule

bind intr_grp intr_grp_chk #(.VALID_MASK(VALID_MASK)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_status  (wr_status),
  .wr_enable  (wr_enable),
  .wr_disable (wr_disable),
  .wr_trigger (wr_trigger),
  .bus_wdata  (bus_wdata),
  .evt_set    (evt_set),
  .status_q   (status_q),
  .mask_q     (mask_q),
  .irq        (irq)
);

// File: tb/sim_intr_grp.sv
module sim_intr_grp;

  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] VALID      = 32'h0000_03F0;
  localparam int          AW         = 5;
  localparam int          WATCHDOG   = 20000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [31:0]   evt_set = '0;
  logic          irq;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  // Behavioural reference state
  logic [31:0] m_status;
  logic [31:0] m_mask;
  logic        m_irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  intr_grp #(.VALID_MASK(VALID), .ADDR_W(AW)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .evt_set   (evt_set),
    .irq       (irq)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_status <= 32'd0;
      m_mask   <= VALID;
      m_irq    <= 1'b0;
    end else begin
      logic [31:0] s;
      logic [31:0] m;
      s = m_status;
      m = m_mask;
      if (bus_sel && bus_wr) begin
        if (bus_addr == 5'h00) s = s & ~bus_wdata;
        if (bus_addr == 5'h08) m = m & ~bus_wdata;
        if (bus_addr == 5'h0C) m = m | (bus_wdata & VALID);
        if (bus_addr == 5'h10) s = s | (bus_wdata & VALID);
      end
      s = s | (evt_set & VALID);
      m_irq    <= ((m_status & ~m_mask) != 32'd0);
      m_status <= s;
      m_mask   <= m;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R9: interrupt line compared with the model on every clock
  always @(negedge clk) begin
    if (rst_n && !done) check("R9", {31'd0, irq}, {31'd0, m_irq});
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input logic [31:0] ev);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; evt_set = ev;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0; evt_set = '0;
  endtask

  task automatic pulse(input logic [31:0] ev);
    @(negedge clk);
    evt_set = ev;
    @(negedge clk);
    evt_set = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    logic [31:0] snap;
    idle(3);
    rst_n = 1'b1;
    // R1 reset state
    rd(5'h00, 32'd0, "R1");
    rd(5'h04, VALID, "R1");
    check("R1", {31'd0, irq}, 32'd0);

    // R6 trigger everything; R10 reserved bits stay 0
    wr(5'h10, 32'hFFFF_FFFF, 32'd0);
    rd(5'h00, 32'h0000_03F0, "R6");
    rd(5'h10, 32'd0, "R6");
    idle(1);
    check("R9", {31'd0, irq}, 32'd0);

    // R4 enable clears mask bits 5:4
    wr(5'h08, 32'h0000_0030, 32'd0);
    rd(5'h04, 32'h0000_03C0, "R4");
    rd(5'h08, 32'd0, "R4");
    check("R9", {31'd0, irq}, 32'd1);

    // R3 direct mask write ignored
    wr(5'h04, 32'd0, 32'd0);
    rd(5'h04, 32'h0000_03C0, "R3");

    // R2 clear bit 4, zero write unchanged
    wr(5'h00, 32'h0000_0010, 32'd0);
    rd(5'h00, 32'h0000_03E0, "R2");
    wr(5'h00, 32'd0, 32'd0);
    rd(5'h00, 32'h0000_03E0, "R2");
    wr(5'h00, 32'h0000_0020, 32'd0);
    rd(5'h00, 32'h0000_03C0, "R2");
    idle(2);
    check("R9", {31'd0, irq}, 32'd0);

    // R10 reserved mask bits ignore enable/disable
    wr(5'h0C, 32'hFFFF_FC0F, 32'd0);
    rd(5'h04, 32'h0000_03C0, "R10");
    wr(5'h08, 32'h0000_03F0, 32'd0);
    rd(5'h04, 32'd0, "R4");
    wr(5'h00, 32'hFFFF_FFFF, 32'd0);
    rd(5'h00, 32'd0, "R2");

    // R5 disable sets mask bit 9
    wr(5'h0C, 32'h0000_0200, 32'd0);
    rd(5'h04, 32'h0000_0200, "R5");
    rd(5'h0C, 32'd0, "R5");

    // R7 events, R10 reserved event bits ignored
    pulse(32'h0000_0008);
    rd(5'h00, 32'd0, "R10");
    pulse(32'h0000_0100);
    rd(5'h00, 32'h0000_0100, "R7");
    pulse(32'h0000_0200);
    rd(5'h00, 32'h0000_0300, "R7");

    // R8 event and clear on the same bit: set wins; other cleared bit goes
    wr(5'h00, 32'h0000_0180, 32'h0000_0080);
    rd(5'h00, 32'h0000_0280, "R8");

    // R11 unmapped and misaligned accesses
    snap = m_status;
    wr(5'h14, 32'hFFFF_FFFF, 32'd0);
    wr(5'h12, 32'hFFFF_FFFF, 32'd0);
    wr(5'h01, 32'hFFFF_FFFF, 32'd0);
    rd(5'h14, 32'd0, "R11");
    rd(5'h01, 32'd0, "R11");
    rd(5'h00, snap, "R11");
    rd(5'h04, 32'h0000_0200, "R11");

    // Model agreement on mixed traffic
    for (int k = 0; k < 20; k++) begin
      wr(5'h10, 32'h0000_0010 << (k % 6), 32'd0);
      if (k % 3 == 0) wr(5'h08, 32'h0000_0040 << (k % 4), 32'd0);
      if (k % 4 == 1) wr(5'h0C, 32'h0000_0010 << (k % 6), 32'd0);
      if (k % 5 == 2) wr(5'h00, 32'h0000_00F0, 32'h0000_0020);
      rd(5'h00, m_status, "R2");
      rd(5'h04, m_mask, "R4");
    end

    // R1 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    rd(5'h00, 32'd0, "R1");
    rd(5'h04, VALID, "R1");
    check("R1", {31'd0, irq}, 32'd0);
    idle(2);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule